// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits beside a local I2C master and watches the shared bus while that master sends data. On every rising edge of the bus clock, inside the data bits of a byte, it compares the level the local master intends for SDA with the level actually present on the bus. If the local side has released SDA high but another master is pulling it low, the local master has lost arbitration. The block then raises a sticky loss flag with a one-cycle pulse, drops the local mode straight to slave receiver, and forces both the local SCL and SDA outputs released (high) until the byte's data bits are over. The other master's transfer then continues undisturbed.

The bus lines are asynchronous to the system clock and pass through a synchronizer and an edge detector before use. A START or STOP seen on the bus restarts the bit position count. Mode bits come from the local controller through a load strobe. Software-side accesses (a data buffer write, a data buffer read, or a write to the second control register) are presented as one-cycle strobes, and any of them clears the loss flag.

Top module: `i2c_arb_monitor`

## Requirements
- R1: Bus SCL and SDA are each passed through a SYNC_STAGES-flop synchronizer, and a bus SCL rising edge is acted on once, SYNC_STAGES+1 system clocks after it reaches the pin; the comparison uses the SDA level synchronized with the same delay.
- R2: A loss (local SDA drive 1, synchronized bus SDA 0, at an SCL rise in a data bit while master and transmitter) sets `arb_lost_o` to 1, where it stays, and gives exactly one one-cycle pulse on `arb_lost_pulse_o` per loss.
- R3: In the cycle the loss is recorded, `mst_o` and `trx_o` both become 0 (slave receiver); otherwise `mode_ld_i` loads them from `mode_mst_i` and `mode_trx_i`.
- R4: From one cycle after a loss until the falling SCL edge that ends the last data bit, `scl_o` is held at 1 whatever `drv_scl_i` does.
- R5: Over the same window `sda_o` is held at 1 whatever `drv_sda_i` does.
- R6: A one-cycle pulse on `buf_wr_i`, `buf_rd_i` or `ctl2_wr_i` clears `arb_lost_o` at the next clock edge; a loss in that same cycle wins.
- R7: No comparison is made unless both mode bits are 1, nor on the acknowledge clock (the SCL rise after the DATA_BITS data bits since the last START or STOP).
- R8: A data-bit SCL rise while master transmitter with local drive 0 and bus SDA 1 gives a one-cycle `bus_fault_o` pulse and does not count as a loss.
- R9: When two masters send bytes MSB first, the local side loses at the first bit where it sends 1 and the other sends 0; if at the first differing bit it sends 0, it keeps master transmitter mode and no loss is flagged.
- R10: Outside the R4/R5 window `scl_o` and `sda_o` follow `drv_scl_i` and `drv_sda_i` one clock later.
- R11: After reset `arb_lost_o`, `arb_lost_pulse_o`, `bus_fault_o`, `mst_o` and `trx_o` are 0 and `scl_o`, `sda_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_scl_i | input | 1 | SCL level sensed on the shared bus |
| bus_sda_i | input | 1 | SDA level sensed on the shared bus |
| drv_scl_i | input | 1 | Local controller's intended SCL (1 = release) |
| drv_sda_i | input | 1 | Local controller's intended SDA (1 = release) |
| mode_ld_i | input | 1 | Load strobe for the mode bits |
| mode_mst_i | input | 1 | Master bit to load |
| mode_trx_i | input | 1 | Transmitter bit to load |
| buf_wr_i | input | 1 | Data buffer write strobe |
| buf_rd_i | input | 1 | Data buffer read strobe |
| ctl2_wr_i | input | 1 | Second control register write strobe |
| scl_o | output | 1 | Registered local SCL drive (1 = release) |
| sda_o | output | 1 | Registered local SDA drive (1 = release) |
| mst_o | output | 1 | Master mode bit |
| trx_o | output | 1 | Transmitter mode bit |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| arb_lost_pulse_o | output | 1 | One-cycle pulse on each loss |
| bus_fault_o | output | 1 | One-cycle pulse when a low drive reads back high |

## Verification
The bench builds the block with DATA_BITS = 4 and SYNC_STAGES = 2. The short byte makes every pair of local and competing bytes reachable, so all 256 pairings are driven on a wired-AND bus model, covering a loss on each bit position, a win at each position, ties, and the case where both bytes agree on their first two bits. Each pairing also toggles the acknowledge level and rotates the clearing strobe, and directed runs cover non-transmitter modes and injected bus faults.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

  // Synchronized view of one bus line
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } line_evt_t;

  // Local operating mode
  typedef struct packed {
    logic mst;
    logic trx;
  } mode_t;

  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int NUM_LINES = 2;

endpackage

// File: rtl/arb_line_sync.sv
module arb_line_sync
  import i2c_arb_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      line_i,
  output line_evt_t evt_o
);

  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain_q;
  logic         prev_q;

  // Idle bus lines are pulled high, so the chain resets to 1
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[TOP-1:0], line_i};
      prev_q  <= chain_q[TOP];
    end
  end

  always_comb begin
    evt_o.level = chain_q[TOP];
    evt_o.rise  = chain_q[TOP] & ~prev_q;
    evt_o.fall  = ~chain_q[TOP] & prev_q;
  end

  // R1
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o.rise |=> !evt_o.rise && evt_o.level);

endmodule

// File: rtl/arb_bit_tracker.sv
module arb_bit_tracker
  import i2c_arb_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  line_evt_t scl_evt_i,
  input  line_evt_t sda_evt_i,
  output logic      data_phase_o,
  output logic      window_end_o,
  output logic      bus_cond_o
);

  localparam int CNT_MAX = DATA_BITS + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(CNT_MAX);
  localparam logic [CW-1:0] CNT_DATA = CW'(DATA_BITS);

  logic [CW-1:0] cnt_q;
  logic          start_det;
  logic          stop_det;

  // START: SDA falls while SCL high; STOP: SDA rises while SCL high
  assign start_det  = sda_evt_i.fall & scl_evt_i.level;
  assign stop_det   = sda_evt_i.rise & scl_evt_i.level;
  assign bus_cond_o = start_det | stop_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (bus_cond_o) begin
      cnt_q <= '0;
    end else if (scl_evt_i.rise && cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Rises with count below DATA_BITS are data bits; the next is acknowledge
  assign data_phase_o = cnt_q < CNT_DATA;
  // Falling SCL after the last data bit closes the clamp window
  assign window_end_o = scl_evt_i.fall && cnt_q == CNT_DATA;

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_TOP);

  // R7
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    bus_cond_o |=> data_phase_o);

endmodule

// File: rtl/arb_mode_ctrl.sv
module arb_mode_ctrl
  import i2c_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  scl_rise_i,
  input  logic  sda_level_i,
  input  logic  data_phase_i,
  input  logic  window_end_i,
  input  logic  bus_cond_i,
  input  logic  drv_sda_i,
  input  logic  mode_ld_i,
  input  mode_t mode_ld_val_i,
  input  logic  flag_clr_i,
  output mode_t mode_o,
  output logic  lost_o,
  output logic  lost_pulse_o,
  output logic  fault_pulse_o,
  output logic  clamp_o
);

  logic compare_en;
  logic lose_now;
  logic fault_now;

  assign compare_en = scl_rise_i & data_phase_i & mode_o.mst & mode_o.trx;
  assign lose_now   = compare_en &  drv_sda_i & ~sda_level_i;
  assign fault_now  = compare_en & ~drv_sda_i &  sda_level_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o        <= '0;
      lost_o        <= 1'b0;
      lost_pulse_o  <= 1'b0;
      fault_pulse_o <= 1'b0;
      clamp_o       <= 1'b0;
    end else begin
      lost_pulse_o  <= lose_now;
      fault_pulse_o <= fault_now;

      if (lose_now)        lost_o <= 1'b1;
      else if (flag_clr_i) lost_o <= 1'b0;

      if (lose_now)       mode_o <= '0;
      else if (mode_ld_i) mode_o <= mode_ld_val_i;

      if (lose_now)                        clamp_o <= 1'b1;
      else if (window_end_i || bus_cond_i) clamp_o <= 1'b0;
    end
  end

  // R2
  flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lost_o) |-> lost_pulse_o);

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lost_o && !flag_clr_i |=> lost_o);

  // R3
  mode_drop_chk: assert property (@(posedge clk) disable iff (rst)
    lost_pulse_o |-> !mode_o.mst && !mode_o.trx);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flag_clr_i && !lose_now |=> !lost_o);

  // R8
  fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fault_pulse_o && lost_pulse_o));

endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_arb_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_scl_i,
  input  logic bus_sda_i,
  input  logic drv_scl_i,
  input  logic drv_sda_i,
  input  logic mode_ld_i,
  input  logic mode_mst_i,
  input  logic mode_trx_i,
  input  logic buf_wr_i,
  input  logic buf_rd_i,
  input  logic ctl2_wr_i,
  output logic scl_o,
  output logic sda_o,
  output logic mst_o,
  output logic trx_o,
  output logic arb_lost_o,
  output logic arb_lost_pulse_o,
  output logic bus_fault_o
);

  logic [NUM_LINES-1:0] raw_lines;
  line_evt_t            evt [NUM_LINES];

  logic  data_phase;
  logic  window_end;
  logic  bus_cond;
  logic  clamp;
  mode_t mode_q;
  mode_t mode_ld_val;
  logic  flag_clr;

  assign raw_lines[LINE_SCL] = bus_scl_i;
  assign raw_lines[LINE_SDA] = bus_sda_i;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
      arb_line_sync #(
        .STAGES (SYNC_STAGES)
      ) sync_i (
        .clk    (clk),
        .rst    (rst),
        .line_i (raw_lines[g]),
        .evt_o  (evt[g])
      );
    end
  endgenerate

  arb_bit_tracker #(
    .DATA_BITS (DATA_BITS)
  ) track_i (
    .clk          (clk),
    .rst          (rst),
    .scl_evt_i    (evt[LINE_SCL]),
    .sda_evt_i    (evt[LINE_SDA]),
    .data_phase_o (data_phase),
    .window_end_o (window_end),
    .bus_cond_o   (bus_cond)
  );

  assign mode_ld_val.mst = mode_mst_i;
  assign mode_ld_val.trx = mode_trx_i;
  assign flag_clr        = buf_wr_i | buf_rd_i | ctl2_wr_i;

  arb_mode_ctrl ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .scl_rise_i    (evt[LINE_SCL].rise),
    .sda_level_i   (evt[LINE_SDA].level),
    .data_phase_i  (data_phase),
    .window_end_i  (window_end),
    .bus_cond_i    (bus_cond),
    .drv_sda_i     (drv_sda_i),
    .mode_ld_i     (mode_ld_i),
    .mode_ld_val_i (mode_ld_val),
    .flag_clr_i    (flag_clr),
    .mode_o        (mode_q),
    .lost_o        (arb_lost_o),
    .lost_pulse_o  (arb_lost_pulse_o),
    .fault_pulse_o (bus_fault_o),
    .clamp_o       (clamp)
  );

  assign mst_o = mode_q.mst;
  assign trx_o = mode_q.trx;

  // Registered line drivers; the clamp releases both lines
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_o <= 1'b1;
      sda_o <= 1'b1;
    end else begin
      scl_o <= clamp ? 1'b1 : drv_scl_i;
      sda_o <= clamp ? 1'b1 : drv_sda_i;
    end
  end

  // R4
  scl_stop_chk: assert property (@(posedge clk) disable iff (rst)
    clamp |=> scl_o);

  // R5
  sda_release_chk: assert property (@(posedge clk) disable iff (rst)
    clamp |=> sda_o);

  // R10
  scl_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !clamp |=> scl_o == $past(drv_scl_i));

  // R3
  loss_needs_mt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost_pulse_o) |-> $past(mst_o) && $past(trx_o));

endmodule

// File: tb/i2c_arb_monitor_tb.sv
module i2c_arb_monitor_tb_top;

  localparam int NB   = 4;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic drv_scl, drv_sda, b_sda, ack_low, fault_inj;
  logic mode_ld, mode_mst, mode_trx;
  logic buf_wr, buf_rd, ctl2_wr;
  logic scl_o, sda_o, mst_o, trx_o, arb_lost_o, arb_lost_pulse_o, bus_fault_o;

  wire bus_scl = drv_scl & scl_o;
  wire bus_sda = (sda_o & b_sda & ~ack_low) | fault_inj;

  i2c_arb_monitor #(
    .DATA_BITS   (NB),
    .SYNC_STAGES (2)
  ) dut_i (
    .clk              (clk),
    .rst              (rst),
    .bus_scl_i        (bus_scl),
    .bus_sda_i        (bus_sda),
    .drv_scl_i        (drv_scl),
    .drv_sda_i        (drv_sda),
    .mode_ld_i        (mode_ld),
    .mode_mst_i       (mode_mst),
    .mode_trx_i       (mode_trx),
    .buf_wr_i         (buf_wr),
    .buf_rd_i         (buf_rd),
    .ctl2_wr_i        (ctl2_wr),
    .scl_o            (scl_o),
    .sda_o            (sda_o),
    .mst_o            (mst_o),
    .trx_o            (trx_o),
    .arb_lost_o       (arb_lost_o),
    .arb_lost_pulse_o (arb_lost_pulse_o),
    .bus_fault_o      (bus_fault_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int pulse_cnt, fault_cnt, lost_at, cur_bit;
  logic b_lost;

  always @(negedge clk) begin
    if (!rst) begin
      if (arb_lost_pulse_o) begin
        pulse_cnt = pulse_cnt + 1;
        lost_at   = cur_bit;
      end
      if (bus_fault_o) fault_cnt = fault_cnt + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // One byte with a competing master; ctype picks the clearing strobe
  task automatic xfer(input logic [NB-1:0] a, input logic [NB-1:0] b,
                      input logic mst, input logic trx, input logic ackl,
                      input int fault_bit, input int ctype);
    int  exp_idx;
    bit  exp_lose;
    int  exp_fault;
    exp_idx  = -1;
    for (int j = NB - 1; j >= 0; j--) begin
      if (exp_idx < 0 && a[j] != b[j]) exp_idx = j;
    end
    exp_lose  = mst && trx && exp_idx >= 0 && a[exp_idx];
    exp_fault = (fault_bit >= 0 && mst && trx && !a[fault_bit]) ? 1 : 0;
    pulse_cnt = 0; fault_cnt = 0; lost_at = -1; b_lost = 1'b0; cur_bit = -1;

    mode_mst = mst; mode_trx = trx; mode_ld = 1'b1;
    tick(1);
    mode_ld = 1'b0;
    drv_scl = 1'b1; drv_sda = 1'b1; b_sda = 1'b1;
    tick(HALF);
    drv_sda = 1'b0; b_sda = 1'b0;            // START
    tick(HALF);
    drv_scl = 1'b0;
    tick(2);
    for (int j = NB - 1; j >= 0; j--) begin
      cur_bit   = j;
      drv_sda   = a[j];
      b_sda     = b_lost ? 1'b1 : b[j];
      fault_inj = (j == fault_bit);
      tick(HALF - 3);
      if (exp_lose && j < exp_idx) begin
        chk("R4 scl held released after loss", int'(scl_o), 1);
        chk("R5 sda held released after loss", int'(sda_o), 1);
      end else begin
        chk("R10 scl follows drive", int'(scl_o), 0);
        chk("R10 sda follows drive", int'(sda_o), int'(a[j]));
      end
      tick(1);
      drv_scl = 1'b1;
      tick(HALF);
      if (b_sda && !bus_sda) b_lost = 1'b1;
      drv_scl = 1'b0;
      tick(2);
      fault_inj = 1'b0;
    end
    cur_bit = -1;
    drv_sda = 1'b1; b_sda = 1'b1; ack_low = ackl;   // acknowledge clock
    tick(HALF - 2);
    drv_scl = 1'b1;
    tick(HALF);
    drv_scl = 1'b0;
    tick(2);
    ack_low = 1'b0; drv_sda = 1'b0; b_sda = 1'b0;
    tick(HALF);
    drv_scl = 1'b1;
    tick(HALF);
    drv_sda = 1'b1; b_sda = 1'b1;            // STOP
    tick(HALF);

    chk("R2 loss pulse count", pulse_cnt, exp_lose ? 1 : 0);
    chk("R2 sticky loss flag", int'(arb_lost_o), exp_lose ? 1 : 0);
    if (exp_lose) chk("R9 loss on first differing bit", lost_at, exp_idx);
    chk("R3 master bit", int'(mst_o), exp_lose ? 0 : int'(mst));
    chk("R3 transmitter bit", int'(trx_o), exp_lose ? 0 : int'(trx));
    chk("R8 bus fault pulses", fault_cnt, exp_fault);

    if (exp_lose) begin
      case (ctype % 3)
        0:       buf_wr  = 1'b1;
        1:       buf_rd  = 1'b1;
        default: ctl2_wr = 1'b1;
      endcase
      tick(1);
      buf_wr = 1'b0; buf_rd = 1'b0; ctl2_wr = 1'b0;
      chk("R6 flag cleared by access strobe", int'(arb_lost_o), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    drv_scl = 1'b1; drv_sda = 1'b1; b_sda = 1'b1; ack_low = 1'b0; fault_inj = 1'b0;
    mode_ld = 1'b0; mode_mst = 1'b0; mode_trx = 1'b0;
    buf_wr = 1'b0; buf_rd = 1'b0; ctl2_wr = 1'b0;
    pulse_cnt = 0; fault_cnt = 0; lost_at = -1; cur_bit = -1; b_lost = 1'b0;
    tick(5);
    rst = 1'b0;
    tick(1);
    chk("R11 reset loss flag", int'(arb_lost_o), 0);
    chk("R11 reset loss pulse", int'(arb_lost_pulse_o), 0);
    chk("R11 reset fault pulse", int'(bus_fault_o), 0);
    chk("R11 reset master bit", int'(mst_o), 0);
    chk("R11 reset transmitter bit", int'(trx_o), 0);
    chk("R11 reset scl released", int'(scl_o), 1);
    chk("R11 reset sda released", int'(sda_o), 1);

    // R9 R1 R7: every pairing of local and competing byte
    for (int a = 0; a < (1 << NB); a++) begin
      for (int b = 0; b < (1 << NB); b++) begin
        xfer(NB'(a), NB'(b), 1'b1, 1'b1, 1'((a + b) & 1), -1, a * (1 << NB) + b);
      end
    end

    // R9: bytes agree on the first two bits, local loses on the third
    xfer(4'b1110, 4'b1100, 1'b1, 1'b1, 1'b0, -1, 0);
    // R9: bytes agree on the first two bits, local wins on the third
    xfer(4'b0100, 4'b0110, 1'b1, 1'b1, 1'b1, -1, 1);
    // R7: receiver or slave mode never compares
    xfer(4'b1111, 4'b0000, 1'b1, 1'b0, 1'b0, -1, 2);
    xfer(4'b1111, 4'b0000, 1'b0, 1'b1, 1'b0, -1, 2);
    // R8: low drive reading back high
    xfer(4'b1010, 4'b1010, 1'b1, 1'b1, 1'b0, 2, 0);
    xfer(4'b1010, 4'b1010, 1'b1, 1'b1, 1'b0, 3, 0);

    summary();
    $finish;
  end

endmodule